// File: doc/BRIEF.md
# Module Reset and Interrupt Sequencer

This block supervises the reset and interrupt signalling of a pluggable module. An active-low reset pin from the host is first synchronised to the system clock. A low level then counts as a reset only if it lasts longer than a set number of clock samples. An accepted reset returns the user settings (the interrupt mask bits) to their defaults and clears every latched status. The block then holds a data-not-ready flag until an initialisation interval has run. That interval is timed from the moment the pin goes high again.

When initialisation ends, data-not-ready clears, a completion flag is latched, and the active-low open-drain interrupt line is pulled low. The same completion event follows power-up, with no pin pulse needed. Status sources for each channel can also raise the interrupt: loss of receive signal, transmit fault, and monitor alarm. Each source has its own mask bit. Flags latch when a source fires and clear when the host reads them. The interrupt is released once no completion flag and no unmasked flag remains.

Top module: `modrst_irq_seq`

## Requirements
- R1: The reset pin passes through SYNC_STAGES flops. A low level is accepted only if it is seen on more than RST_MIN_CYC consecutive clock samples. A low pulse of RST_MIN_CYC samples or fewer leaves data-not-ready, flags and mask bits unchanged.
- R2: An accepted reset restores every mask bit to MASK_DEF (by default all zero, so every source is enabled) and clears the status flags and the completion flag. This takes effect RST_MIN_CYC+4 cycles after the clock edge at which the pin is first sampled low by the bench's drive.
- R3: Data-not-ready is 1 while an accepted reset is held and throughout initialisation. Initialisation lasts INIT_CYC cycles from the release of the pin. Data-not-ready clears INIT_CYC+4 cycles after the pin rises.
- R4: In the cycle data-not-ready clears, the completion flag sets and irq_drv_lo becomes 1. irq_drv_lo = 1 means pull the line low; the line is never driven high.
- R5: While rst is high: data-not-ready = 1, completion = 0, flags = 0, irq_drv_lo = 0. After rst falls, completion is posted INIT_CYC cycles later with no pin pulse.
- R6: Flag bit ch*3+s belongs to channel ch, where s is 0 for receive loss, 1 for transmit fault and 2 for monitor alarm. A source high in a cycle when data-not-ready is 0 sets its flag one cycle later, and the flag stays set. Sources are ignored while data-not-ready is 1.
- R7: A mask bit of 1 keeps its flag from driving the interrupt, but the flag still latches. Mask writes take effect on the next cycle.
- R8: rd_clr clears all flags and the completion flag on the next cycle. A source that is high in the same cycle as rd_clr stays latched.
- R9: irq_drv_lo is 1 exactly when the completion flag or an unmasked flag is set. It drops in the cycle after the last one is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| rst_pin_n | input | 1 | Asynchronous active-low module reset pin |
| stat_src | input | N_CH*3 | Per-channel status source levels |
| rd_clr | input | 1 | Host read strobe, clears latched flags |
| mask_we | input | 1 | Mask register write enable |
| mask_wd | input | N_CH*3 | Mask write data, 1 = masked |
| dnr | output | 1 | Data-not-ready flag |
| cpl_flag | output | 1 | Latched reset-completion flag |
| stat_flags | output | N_CH*3 | Latched status flags |
| irq_drv_lo | output | 1 | Open-drain enable, 1 pulls the interrupt line low |

## Verification
Each result has a fixed due cycle, counted from the falling clock edge at which the bench drives a stimulus:
- A source, mask write or read strobe shows up on the outputs one cycle later.
- A pin fall is acted on RST_MIN_CYC+4 cycles later: two synchroniser stages, the qualifying count and the sequencer register.
- A pin rise ends data-not-ready INIT_CYC+4 cycles later.
- Power-up completion is due INIT_CYC cycles after rst falls.

The driver records each expected output with its due cycle. For every reset and completion boundary it also records the cycle just before, so an off-by-one in either direction is caught. The monitor compares only the items whose due cycle matches the current one, sampling 2 ns after the rising edge.

// File: rtl/modrst_pkg.sv
package modrst_pkg;

    // number of status sources per channel
    localparam int unsigned N_SRC = 3;

    // source position inside one channel group
    typedef enum logic [1:0] {
        SRC_RX_LOS    = 2'd0,
        SRC_TX_FAULT  = 2'd1,
        SRC_MON_ALARM = 2'd2
    } src_e;

    // per-channel status group, bit 0 = receive loss
    typedef struct packed {
        logic mon_alarm;
        logic tx_fault;
        logic rx_los;
    } chan_stat_t;

    // sequencer states
    typedef enum logic [1:0] {
        SEQ_INIT  = 2'd0,
        SEQ_HOLD  = 2'd1,
        SEQ_READY = 2'd2
    } seq_state_e;

    // flat flag index of a channel source
    function automatic int unsigned flag_idx(int unsigned ch, src_e s);
        return ch * N_SRC + int'(s);
    endfunction

    // counter width able to hold the value n
    function automatic int unsigned cnt_w(int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/modrst_sync.sv
module modrst_sync #(
    parameter int unsigned STAGES  = 2,
    parameter logic        RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= {STAGES{RST_VAL}};
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                chain[i] <= chain[i-1];
            end
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/modrst_pulse_qual.sv
module modrst_pulse_qual
    import modrst_pkg::*;
#(
    parameter int unsigned MIN_LOW = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_s,
    output logic hold
);
    localparam int unsigned CW = cnt_w(MIN_LOW);

    logic [CW-1:0] low_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            low_cnt <= '0;
            hold    <= 1'b0;
        end else if (pin_s) begin
            low_cnt <= '0;
            hold    <= 1'b0;
        end else if (low_cnt == CW'(MIN_LOW)) begin
            hold    <= 1'b1;
        end else begin
            low_cnt <= low_cnt + 1'b1;
        end
    end

    // R1
    hold_needs_low_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(hold) |-> !$past(pin_s));

    // R1
    hold_drops_on_high_chk: assert property (@(posedge clk) disable iff (rst)
        pin_s |=> !hold);

endmodule

// File: rtl/modrst_init_timer.sv
module modrst_init_timer
    import modrst_pkg::*;
#(
    parameter int unsigned INIT_CYC = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic hold,
    output logic dnr,
    output logic done
);
    localparam int unsigned CW = cnt_w(INIT_CYC);

    seq_state_e    st;
    logic [CW-1:0] cnt;
    logic          last;

    assign last = (cnt == CW'(INIT_CYC - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= SEQ_INIT;
            cnt <= '0;
        end else if (hold) begin
            st  <= SEQ_HOLD;
            cnt <= '0;
        end else begin
            unique case (st)
                SEQ_HOLD: begin
                    st  <= SEQ_INIT;
                    cnt <= '0;
                end
                SEQ_INIT: begin
                    if (last) st <= SEQ_READY;
                    else      cnt <= cnt + 1'b1;
                end
                default: st <= SEQ_READY;
            endcase
        end
    end

    assign dnr  = (st != SEQ_READY);
    assign done = (st == SEQ_INIT) && last && !hold;

    // R3
    init_cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(INIT_CYC - 1));

    // R3
    hold_keeps_dnr_chk: assert property (@(posedge clk) disable iff (rst)
        hold |=> dnr);

endmodule

// File: rtl/modrst_irq_ctrl.sv
module modrst_irq_ctrl
    import modrst_pkg::*;
#(
    parameter int unsigned             N_CH     = 4,
    parameter logic [N_CH*N_SRC-1:0]   MASK_DEF = '0
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   soft_rst,
    input  logic                   dnr,
    input  logic                   done,
    input  logic [N_CH*N_SRC-1:0]  stat_src,
    input  logic                   rd_clr,
    input  logic                   mask_we,
    input  logic [N_CH*N_SRC-1:0]  mask_wd,
    output logic [N_CH*N_SRC-1:0]  flags,
    output logic                   cpl,
    output logic                   irq_lo
);
    localparam int unsigned NF = N_CH * N_SRC;

    chan_stat_t        flag_c [N_CH];
    chan_stat_t        mask_c [N_CH];
    logic [NF-1:0]     mask_flat;
    logic [N_CH-1:0]   pend;

    for (genvar g = 0; g < N_CH; g++) begin : g_chan
        chan_stat_t src_g;
        chan_stat_t keep_g;

        assign src_g  = dnr    ? chan_stat_t'('0) : chan_stat_t'(stat_src[g*N_SRC +: N_SRC]);
        assign keep_g = rd_clr ? chan_stat_t'('0) : flag_c[g];

        always_ff @(posedge clk) begin
            if (rst || soft_rst) begin
                flag_c[g] <= '0;
                mask_c[g] <= chan_stat_t'(MASK_DEF[g*N_SRC +: N_SRC]);
            end else begin
                flag_c[g] <= keep_g | src_g;
                if (mask_we) begin
                    mask_c[g] <= chan_stat_t'(mask_wd[g*N_SRC +: N_SRC]);
                end
            end
        end

        assign flags[g*N_SRC +: N_SRC]     = flag_c[g];
        assign mask_flat[g*N_SRC +: N_SRC] = mask_c[g];
        assign pend[g] = |(flag_c[g] & ~mask_c[g]);
    end

    always_ff @(posedge clk) begin
        if (rst || soft_rst) begin
            cpl <= 1'b0;
        end else begin
            cpl <= (cpl && !rd_clr) || done;
        end
    end

    assign irq_lo = cpl || (|pend);

    // R6
    flags_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        dnr |-> flags == '0);

    // R2
    mask_default_chk: assert property (@(posedge clk) disable iff (rst)
        $past(soft_rst) |-> mask_flat == MASK_DEF);

    // R9
    clr_release_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_clr && stat_src == '0 && !done) |=> !irq_lo);

endmodule

// File: rtl/modrst_irq_seq.sv
module modrst_irq_seq
    import modrst_pkg::*;
#(
    parameter int unsigned           N_CH        = 4,
    parameter int unsigned           SYNC_STAGES = 2,
    parameter int unsigned           RST_MIN_CYC = 1000,
    parameter int unsigned           INIT_CYC    = 50000,
    parameter logic [N_CH*N_SRC-1:0] MASK_DEF    = '0
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  rst_pin_n,
    input  logic [N_CH*N_SRC-1:0] stat_src,
    input  logic                  rd_clr,
    input  logic                  mask_we,
    input  logic [N_CH*N_SRC-1:0] mask_wd,
    output logic                  dnr,
    output logic                  cpl_flag,
    output logic [N_CH*N_SRC-1:0] stat_flags,
    output logic                  irq_drv_lo
);
    logic pin_s;
    logic hold;
    logic done;

    modrst_sync #(
        .STAGES  (SYNC_STAGES),
        .RST_VAL (1'b1)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (rst_pin_n),
        .q   (pin_s)
    );

    modrst_pulse_qual #(
        .MIN_LOW (RST_MIN_CYC)
    ) u_qual (
        .clk   (clk),
        .rst   (rst),
        .pin_s (pin_s),
        .hold  (hold)
    );

    modrst_init_timer #(
        .INIT_CYC (INIT_CYC)
    ) u_timer (
        .clk  (clk),
        .rst  (rst),
        .hold (hold),
        .dnr  (dnr),
        .done (done)
    );

    modrst_irq_ctrl #(
        .N_CH     (N_CH),
        .MASK_DEF (MASK_DEF)
    ) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .soft_rst (hold),
        .dnr      (dnr),
        .done     (done),
        .stat_src (stat_src),
        .rd_clr   (rd_clr),
        .mask_we  (mask_we),
        .mask_wd  (mask_wd),
        .flags    (stat_flags),
        .cpl      (cpl_flag),
        .irq_lo   (irq_drv_lo)
    );

    // R4
    dnr_fall_posts_cpl_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(dnr) |-> (cpl_flag && irq_drv_lo));

    // R4
    cpl_only_when_ready_chk: assert property (@(posedge clk) disable iff (rst)
        cpl_flag |-> !dnr);

endmodule

// File: tb/modrst_irq_seq_bench.sv
module modrst_irq_seq_bench;
    import modrst_pkg::*;

    localparam int N_CH = 2;
    localparam int NF   = N_CH * N_SRC;
    localparam int MINL = 5;
    localparam int INIT = 20;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          pin_n = 1'b1;
    logic          rd_clr = 1'b0;
    logic          mask_we = 1'b0;
    logic [NF-1:0] src = '0;
    logic [NF-1:0] mask_wd = '0;
    logic          dnr, cpl, irq;
    logic [NF-1:0] flags;

    modrst_irq_seq #(
        .N_CH        (N_CH),
        .SYNC_STAGES (2),
        .RST_MIN_CYC (MINL),
        .INIT_CYC    (INIT),
        .MASK_DEF    ('0)
    ) u_modrst_irq_seq (
        .clk        (clk),
        .rst        (rst),
        .rst_pin_n  (pin_n),
        .stat_src   (src),
        .rd_clr     (rd_clr),
        .mask_we    (mask_we),
        .mask_wd    (mask_wd),
        .dnr        (dnr),
        .cpl_flag   (cpl),
        .stat_flags (flags),
        .irq_drv_lo (irq)
    );

    always #5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int            due;
        string         req;
        logic          dnr;
        logic          irq;
        logic          cpl;
        logic [NF-1:0] flags;
    } exp_t;

    exp_t sb[$];
    int   n_vec = 0;
    int   n_bad = 0;
    bit   fin   = 1'b0;

    function automatic logic [NF-1:0] fb(int unsigned i);
        return NF'(1) << i;
    endfunction

    task automatic push(int dly, string req, logic d, logic i, logic c, logic [NF-1:0] f);
        exp_t e;
        e.due = cyc + dly; e.req = req;
        e.dnr = d; e.irq = i; e.cpl = c; e.flags = f;
        sb.push_back(e);
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: pop items that fall due and compare
    initial begin
        forever begin
            @(posedge clk);
            #2;
            for (int k = sb.size() - 1; k >= 0; k--) begin
                if (sb[k].due == cyc) begin
                    n_vec++;
                    if (dnr !== sb[k].dnr || irq !== sb[k].irq ||
                        cpl !== sb[k].cpl || flags !== sb[k].flags) begin
                        n_bad++;
                        $display("FAIL %s cyc %0d: dnr=%b irq=%b cpl=%b flags=%h expected dnr=%b irq=%b cpl=%b flags=%h",
                                 sb[k].req, cyc, dnr, irq, cpl, flags,
                                 sb[k].dnr, sb[k].irq, sb[k].cpl, sb[k].flags);
                    end
                    sb.delete(k);
                end
            end
        end
    end

    task automatic finish_run();
        if (!fin) begin
            fin = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 10);
        n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        finish_run();
    end

    initial begin
        // R5: state while rst is high, then power-up completion
        step(3);
        push(1, "R5 reset state", 1, 0, 0, '0);
        step(1);
        rst = 1'b0;
        push(INIT - 1, "R5 still initialising", 1, 0, 0, '0);
        push(INIT,     "R5 power-up completion", 0, 1, 1, '0);
        step(5);
        // R6: sources ignored while dnr is set
        src = fb(flag_idx(0, SRC_RX_LOS));
        push(1, "R6 ignored during init", 1, 0, 0, '0);
        step(1);
        src = '0;
        step(INIT);

        // R8: host read clears the completion flag
        rd_clr = 1'b1;
        push(1, "R8 clear completion", 0, 0, 0, '0);
        step(1);
        rd_clr = 1'b0;

        // R6: transmit fault on channel 1 latches into bit 4
        src = fb(flag_idx(1, SRC_TX_FAULT));
        push(1, "R6 latch", 0, 1, 0, fb(4));
        step(1);
        src = '0;
        push(2, "R6 held after source drop", 0, 1, 0, fb(4));
        step(3);
        rd_clr = 1'b1;
        push(1, "R9 release", 0, 0, 0, '0);
        step(1);
        rd_clr = 1'b0;

        // R7: mask bit 4
        mask_we = 1'b1;
        mask_wd = fb(4);
        step(1);
        mask_we = 1'b0;
        src = fb(4);
        push(1, "R7 masked flag latches, no irq", 0, 0, 0, fb(4));
        step(1);
        src = fb(0);
        push(1, "R7 unmasked source raises irq", 0, 1, 0, fb(4) | fb(0));
        step(1);
        src = '0;
        step(1);
        // R8: new event in the read cycle survives
        rd_clr = 1'b1;
        src = fb(flag_idx(0, SRC_MON_ALARM));
        push(1, "R8 same-cycle event kept", 0, 1, 0, fb(2));
        step(1);
        rd_clr = 1'b0;
        src = '0;
        rd_clr = 1'b1;
        push(1, "R9 release after read", 0, 0, 0, '0);
        step(1);
        rd_clr = 1'b0;

        // R1: pulse of exactly the minimum length is ignored
        pin_n = 1'b0;
        for (int k = 1; k <= MINL + 8; k++) push(k, "R1 short pulse ignored", 0, 0, 0, '0);
        step(MINL);
        pin_n = 1'b1;
        step(9);
        src = fb(4);
        push(1, "R1 mask setting kept", 0, 0, 0, fb(4));
        step(1);
        src = '0;
        rd_clr = 1'b1;
        push(1, "R8 clear", 0, 0, 0, '0);
        step(1);
        rd_clr = 1'b0;

        // R2/R3: one sample over the minimum is accepted
        src = fb(0);
        step(1);
        src = '0;
        step(1);
        pin_n = 1'b0;
        push(MINL + 3, "R2 before accepted reset", 0, 1, 0, fb(0));
        push(MINL + 4, "R2 flags cleared, dnr set", 1, 0, 0, '0);
        step(MINL + 1);
        pin_n = 1'b1;
        push(INIT + 3, "R3 still initialising", 1, 0, 0, '0);
        push(INIT + 4, "R4 completion after release", 0, 1, 1, '0);
        step(INIT + 6);
        rd_clr = 1'b1;
        push(1, "R8 clear", 0, 0, 0, '0);
        step(1);
        rd_clr = 1'b0;
        src = fb(4);
        push(1, "R2 mask back to default", 0, 1, 0, fb(4));
        step(1);
        src = '0;
        rd_clr = 1'b1;
        push(1, "R9 release", 0, 0, 0, '0);
        step(1);
        rd_clr = 1'b0;

        // R3: long hold, timing from release
        pin_n = 1'b0;
        step(20);
        src = fb(1);
        push(1, "R3 dnr while held", 1, 0, 0, '0);
        step(1);
        src = '0;
        step(9);
        pin_n = 1'b1;
        push(INIT + 3, "R3 long hold still initialising", 1, 0, 0, '0);
        push(INIT + 4, "R3 long hold completion", 0, 1, 1, '0);
        step(INIT + 6);

        step(3);
        if (sb.size() != 0) begin
            n_bad += sb.size();
            $display("FAIL scoreboard: %0d items never due, expected 0", sb.size());
        end
        finish_run();
    end

endmodule